// File: doc/BRIEF.md
# Display Mode to Timing Converter

This block turns a display mode, given as display size, sync start, sync end and total on each axis, into the parameter set a video timing engine is loaded with. For each axis it produces active size, front porch, back porch, sync pulse width and sync polarity. It also decides how many lines of early fetch to schedule, and it computes the value of the frame position counter at which that fetch is triggered. Modes whose fields are out of order are rejected: every output reads zero and the valid flag stays low.

The caller presents a mode and pulses `start_i` for one cycle. The block captures the mode in that cycle. A split-display setting halves the horizontal fields at capture. The interface kind then selects the polarity and porch handling. A sequential shift-add multiplier forms the fetch trigger value. When it finishes, every output is loaded at once and `done_o` pulses for one cycle. The outputs then hold until the next run completes. While a run is in progress the block applies no back-pressure: a start strobe that arrives during a run is dropped. The caller must wait for `done_o` before it issues the next mode.

Top module: `mode_timing_conv`

## Requirements
- R1: After reset, `done_o`, `valid_o`, `fetch_en_o` and every numeric output are 0.
- R2: A mode in which any of these holds is rejected: htotal < hsync_end, hsync_start < hdisplay, hsync_end < hsync_start, vtotal < vsync_end, vsync_start < vdisplay, or vsync_end < vsync_start. For a rejected mode `valid_o` is 0 and all other outputs, the colour outputs included, are 0. Otherwise `valid_o` is 1.
- R3: Each axis is derived in the same way: active = display, front porch = sync_start − display, pulse width = sync_end − sync_start, and back porch = total − sync_end.
- R4: When `split_i` = 1, the horizontal display, sync start, sync end and total are each shifted right by one bit before any check or derivation. The vertical fields are used unchanged.
- R5: `h_pol_o` equals `h_neg_i` and `v_pol_o` equals `v_neg_i`, except when `if_kind_i` = 1 (a command-style serial panel link). In that case both polarities are 0.
- R6: When `if_kind_i` is 2 or 3 (packetised display links), on both axes the front porch is added into the back porch and the front porch output is 0. Kind 0 applies no such change.
- R7: With S = vertical back porch + vertical pulse width, taken after folding, and WC = parameter `WORST_LINES` (default 24), `fetch_lines_o` works out as follows. It is 0 when S ≥ WC. It is the vertical front porch when that porch is smaller than WC − S. Otherwise it is WC − S.
- R8: `fetch_en_o` is 1 exactly when `fetch_lines_o` ≠ 0. In that case `fetch_start_o` = (VT − fetch_lines) × HT + 1, where each total is active + front porch + back porch + pulse width on its axis, taken after folding. Otherwise `fetch_start_o` = 0.
- R9: For an accepted mode, `border_clr_o` is 0 and `underflow_clr_o` is all ones (0xFF by default).
- R10: `done_o` is a one-cycle pulse, and all outputs take their new values in that cycle. The outputs stay unchanged until the next completion. A `start_i` that arrives before `done_o` of the run in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe: capture the mode and begin |
| h_disp_i | input | 16 | Horizontal display size |
| h_ss_i | input | 16 | Horizontal sync start |
| h_se_i | input | 16 | Horizontal sync end |
| h_tot_i | input | 16 | Horizontal total |
| v_disp_i | input | 16 | Vertical display size |
| v_ss_i | input | 16 | Vertical sync start |
| v_se_i | input | 16 | Vertical sync end |
| v_tot_i | input | 16 | Vertical total |
| h_neg_i | input | 1 | Horizontal sync is active low |
| v_neg_i | input | 1 | Vertical sync is active low |
| if_kind_i | input | 2 | Interface kind: 0 plain, 1 command serial, 2/3 packetised |
| split_i | input | 1 | 1 = split display, halve horizontal |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Mode accepted |
| h_active_o | output | 16 | Horizontal active size |
| h_fp_o | output | 16 | Horizontal front porch |
| h_bp_o | output | 16 | Horizontal back porch |
| h_pw_o | output | 16 | Horizontal sync pulse width |
| h_pol_o | output | 1 | Horizontal sync polarity |
| v_active_o | output | 16 | Vertical active size |
| v_fp_o | output | 16 | Vertical front porch |
| v_bp_o | output | 16 | Vertical back porch |
| v_pw_o | output | 16 | Vertical sync pulse width |
| v_pol_o | output | 1 | Vertical sync polarity |
| fetch_en_o | output | 1 | Early fetch enabled |
| fetch_lines_o | output | 16 | Early fetch line count |
| fetch_start_o | output | 32 | Frame counter value that triggers the fetch |
| border_clr_o | output | 8 | Border colour |
| underflow_clr_o | output | 8 | Underflow colour |

## Verification
The hardest situation to reach from the ports is a second start strobe that lands in the middle of a multiplication. It can only be seen through the fact that the later mode never shows up at the outputs. The bench reaches it by pulsing `start_i` a few cycles into a run with a clearly different mode, and then checking that the result matches the first mode. The exact edges of the three-way fetch decision also need constructed vertical timings: a start-of-frame span exactly equal to the worst case, a front porch exactly equal to the shortfall, and a packetised link whose folded front porch is zero. Directed modes hit these edges, and random modes spread around the worst-case line count.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    IF_PLAIN = 2'd0,
    IF_CMD   = 2'd1,
    IF_PKT_A = 2'd2,
    IF_PKT_B = 2'd3
  } if_kind_e;

  function automatic logic kind_folds(if_kind_e k);
    return (k == IF_PKT_A) || (k == IF_PKT_B);
  endfunction

  function automatic logic kind_no_pol(if_kind_e k);
    return k == IF_CMD;
  endfunction
endpackage

// File: rtl/mtc_axis.sv
module mtc_axis
  import mtc_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic [FW-1:0] disp_i,
  input  logic [FW-1:0] ss_i,
  input  logic [FW-1:0] se_i,
  input  logic [FW-1:0] tot_i,
  input  logic          neg_i,
  input  if_kind_e      kind_i,
  output logic          ok_o,
  output logic [FW-1:0] act_o,
  output logic [FW-1:0] fp_o,
  output logic [FW-1:0] bp_o,
  output logic [FW-1:0] pw_o,
  output logic [FW-1:0] sum_o,
  output logic          pol_o
);
  logic [FW-1:0] fp_raw, bp_raw;

  always_comb begin
    ok_o   = (tot_i >= se_i) && (ss_i >= disp_i) && (se_i >= ss_i);
    fp_raw = ss_i - disp_i;
    bp_raw = tot_i - se_i;
    act_o  = disp_i;
    pw_o   = se_i - ss_i;
    if (kind_folds(kind_i)) begin
      bp_o = bp_raw + fp_raw;
      fp_o = '0;
    end else begin
      bp_o = bp_raw;
      fp_o = fp_raw;
    end
    sum_o = act_o + fp_o + bp_o + pw_o;
    pol_o = neg_i && !kind_no_pol(kind_i);
  end
endmodule

// File: rtl/mtc_fetch.sv
module mtc_fetch #(
  parameter int FW          = 16,
  parameter int WORST_LINES = 24
) (
  input  logic [FW-1:0] vbp_i,
  input  logic [FW-1:0] vpw_i,
  input  logic [FW-1:0] vfp_i,
  output logic [FW-1:0] lines_o
);
  localparam int EW = FW + 1;
  localparam logic [EW-1:0] WC = EW'(WORST_LINES);

  logic [EW-1:0] sof, need;

  always_comb begin
    sof  = {1'b0, vbp_i} + {1'b0, vpw_i};
    need = WC - sof;
    if (sof >= WC)
      lines_o = '0;
    else if ({1'b0, vfp_i} < need)
      lines_o = vfp_i;
    else
      lines_o = need[FW-1:0];
  end
endmodule

// File: rtl/mtc_seq_mult.sv
module mtc_seq_mult #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o,
  output logic           fin_o
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic [PW-1:0] mcand;
  logic [W-1:0]  mplier;
  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        prod_o <= '0;
        mcand  <= PW'(a_i);
        mplier <= b_i;
        cnt    <= CW'(W);
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) prod_o <= prod_o + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy  <= 1'b0;
          fin_o <= 1'b1;
        end
      end
    end
  end

  // R10
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);
endmodule

// File: rtl/mode_timing_conv.sv
module mode_timing_conv
  import mtc_pkg::*;
#(
  parameter int FW          = 16,
  parameter int WORST_LINES = 24,
  parameter int CLR_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FW-1:0]      h_disp_i,
  input  logic [FW-1:0]      h_ss_i,
  input  logic [FW-1:0]      h_se_i,
  input  logic [FW-1:0]      h_tot_i,
  input  logic [FW-1:0]      v_disp_i,
  input  logic [FW-1:0]      v_ss_i,
  input  logic [FW-1:0]      v_se_i,
  input  logic [FW-1:0]      v_tot_i,
  input  logic               h_neg_i,
  input  logic               v_neg_i,
  input  logic [1:0]         if_kind_i,
  input  logic               split_i,
  output logic               done_o,
  output logic               valid_o,
  output logic [FW-1:0]      h_active_o,
  output logic [FW-1:0]      h_fp_o,
  output logic [FW-1:0]      h_bp_o,
  output logic [FW-1:0]      h_pw_o,
  output logic               h_pol_o,
  output logic [FW-1:0]      v_active_o,
  output logic [FW-1:0]      v_fp_o,
  output logic [FW-1:0]      v_bp_o,
  output logic [FW-1:0]      v_pw_o,
  output logic               v_pol_o,
  output logic               fetch_en_o,
  output logic [FW-1:0]      fetch_lines_o,
  output logic [2*FW-1:0]    fetch_start_o,
  output logic [CLR_W-1:0]   border_clr_o,
  output logic [CLR_W-1:0]   underflow_clr_o
);
  localparam int NAX = 2;
  localparam int PW  = 2 * FW;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_MUL} state_e;
  state_e state;

  logic [FW-1:0] c_disp [NAX];
  logic [FW-1:0] c_ss   [NAX];
  logic [FW-1:0] c_se   [NAX];
  logic [FW-1:0] c_tot  [NAX];
  logic          c_neg  [NAX];
  if_kind_e      c_kind;

  logic          a_ok  [NAX];
  logic [FW-1:0] a_act [NAX];
  logic [FW-1:0] a_fp  [NAX];
  logic [FW-1:0] a_bp  [NAX];
  logic [FW-1:0] a_pw  [NAX];
  logic [FW-1:0] a_sum [NAX];
  logic          a_pol [NAX];

  logic [FW-1:0] f_lines;
  logic [FW-1:0] op_a;
  logic [PW-1:0] prod;
  logic          mul_go, mul_fin, mode_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      c_kind <= IF_PLAIN;
      for (int i = 0; i < NAX; i++) begin
        c_disp[i] <= '0;
        c_ss[i]   <= '0;
        c_se[i]   <= '0;
        c_tot[i]  <= '0;
        c_neg[i]  <= 1'b0;
      end
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          state  <= S_LOAD;
          c_kind <= if_kind_e'(if_kind_i);
          c_neg[0] <= h_neg_i;
          c_neg[1] <= v_neg_i;
          c_disp[1] <= v_disp_i;
          c_ss[1]   <= v_ss_i;
          c_se[1]   <= v_se_i;
          c_tot[1]  <= v_tot_i;
          if (split_i) begin
            c_disp[0] <= h_disp_i >> 1;
            c_ss[0]   <= h_ss_i >> 1;
            c_se[0]   <= h_se_i >> 1;
            c_tot[0]  <= h_tot_i >> 1;
          end else begin
            c_disp[0] <= h_disp_i;
            c_ss[0]   <= h_ss_i;
            c_se[0]   <= h_se_i;
            c_tot[0]  <= h_tot_i;
          end
        end
        S_LOAD: state <= S_MUL;
        S_MUL:  if (mul_fin) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    mtc_axis #(.FW(FW)) u_axis (
      .disp_i (c_disp[g]),
      .ss_i   (c_ss[g]),
      .se_i   (c_se[g]),
      .tot_i  (c_tot[g]),
      .neg_i  (c_neg[g]),
      .kind_i (c_kind),
      .ok_o   (a_ok[g]),
      .act_o  (a_act[g]),
      .fp_o   (a_fp[g]),
      .bp_o   (a_bp[g]),
      .pw_o   (a_pw[g]),
      .sum_o  (a_sum[g]),
      .pol_o  (a_pol[g])
    );
  end

  mtc_fetch #(.FW(FW), .WORST_LINES(WORST_LINES)) u_fetch (
    .vbp_i   (a_bp[1]),
    .vpw_i   (a_pw[1]),
    .vfp_i   (a_fp[1]),
    .lines_o (f_lines)
  );

  assign mode_ok = a_ok[0] && a_ok[1];
  assign op_a    = a_sum[1] - f_lines;
  assign mul_go  = (state == S_LOAD);

  mtc_seq_mult #(.W(FW)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (mul_go),
    .a_i    (op_a),
    .b_i    (a_sum[0]),
    .prod_o (prod),
    .fin_o  (mul_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      valid_o <= 1'b0;
      h_active_o <= '0; h_fp_o <= '0; h_bp_o <= '0; h_pw_o <= '0; h_pol_o <= 1'b0;
      v_active_o <= '0; v_fp_o <= '0; v_bp_o <= '0; v_pw_o <= '0; v_pol_o <= 1'b0;
      fetch_en_o <= 1'b0;
      fetch_lines_o <= '0;
      fetch_start_o <= '0;
      border_clr_o <= '0;
      underflow_clr_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (state == S_MUL && mul_fin) begin
        done_o <= 1'b1;
        if (mode_ok) begin
          valid_o <= 1'b1;
          h_active_o <= a_act[0]; h_fp_o <= a_fp[0]; h_bp_o <= a_bp[0];
          h_pw_o <= a_pw[0]; h_pol_o <= a_pol[0];
          v_active_o <= a_act[1]; v_fp_o <= a_fp[1]; v_bp_o <= a_bp[1];
          v_pw_o <= a_pw[1]; v_pol_o <= a_pol[1];
          fetch_en_o <= (f_lines != '0);
          fetch_lines_o <= f_lines;
          fetch_start_o <= (f_lines != '0) ? prod + PW'(1) : '0;
          border_clr_o <= '0;
          underflow_clr_o <= '1;
        end else begin
          valid_o <= 1'b0;
          h_active_o <= '0; h_fp_o <= '0; h_bp_o <= '0; h_pw_o <= '0; h_pol_o <= 1'b0;
          v_active_o <= '0; v_fp_o <= '0; v_bp_o <= '0; v_pw_o <= '0; v_pol_o <= 1'b0;
          fetch_en_o <= 1'b0;
          fetch_lines_o <= '0;
          fetch_start_o <= '0;
          border_clr_o <= '0;
          underflow_clr_o <= '0;
        end
      end
    end
  end

  // R2
  reject_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (!fetch_en_o && fetch_start_o == '0 && h_active_o == '0 &&
                  v_active_o == '0 && h_bp_o == '0 && v_bp_o == '0 &&
                  underflow_clr_o == '0));
  // R8
  fetch_en_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_o == (fetch_lines_o != '0)) && (fetch_en_o -> fetch_start_o != '0));
  // R7
  fetch_in_vfp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_lines_o <= v_fp_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_fin |=> ($stable(fetch_start_o) && $stable(valid_o) && $stable(h_bp_o) &&
                  $stable(v_fp_o) && !done_o));
  // R5
  cmd_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && c_kind == IF_CMD) |-> (!h_pol_o && !v_pol_o));
  // R6
  fold_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_folds(c_kind)) |-> (h_fp_o == '0 && v_fp_o == '0));
  // R9
  colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (border_clr_o == '0 && underflow_clr_o == '1));
endmodule

// File: tb/sim_mode_timing_conv.sv
module sim_mode_timing_conv;
  localparam int WC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start_i = 1'b0;
  logic [15:0] h_disp_i = '0, h_ss_i = '0, h_se_i = '0, h_tot_i = '0;
  logic [15:0] v_disp_i = '0, v_ss_i = '0, v_se_i = '0, v_tot_i = '0;
  logic        h_neg_i = 1'b0, v_neg_i = 1'b0, split_i = 1'b0;
  logic [1:0]  if_kind_i = '0;
  logic        done_o, valid_o, h_pol_o, v_pol_o, fetch_en_o;
  logic [15:0] h_active_o, h_fp_o, h_bp_o, h_pw_o;
  logic [15:0] v_active_o, v_fp_o, v_bp_o, v_pw_o, fetch_lines_o;
  logic [31:0] fetch_start_o;
  logic [7:0]  border_clr_o, underflow_clr_o;

  mode_timing_conv u0 (.*);

  typedef struct {
    int hd, hs, he, ht, vd, vs, ve, vt;
    bit hn, vn, sp;
    int kind;
  } mode_t;

  typedef struct {
    bit valid, hp, vp, en;
    logic [63:0] hv, vv;
    int lines;
    logic [31:0] fstart;
    logic [7:0] bc, uc;
  } exp_t;

  int n_checks = 0, n_err = 0;
  int wd = 0;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_err = n_err + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input mode_t m);
    exp_t e;
    int hd, hs, he, ht, hfp, hbp, hpw, vfp, vbp, vpw, sof, need, htot, vtot;
    bit fold;
    hd = m.hd; hs = m.hs; he = m.he; ht = m.ht;
    if (m.sp) begin hd = hd / 2; hs = hs / 2; he = he / 2; ht = ht / 2; end
    e = '{default: 0};
    if (ht < he || hs < hd || he < hs || m.vt < m.ve || m.vs < m.vd || m.ve < m.vs)
      return e;
    fold = (m.kind == 2) || (m.kind == 3);
    hfp = hs - hd; hbp = ht - he; hpw = he - hs;
    vfp = m.vs - m.vd; vbp = m.vt - m.ve; vpw = m.ve - m.vs;
    if (fold) begin hbp += hfp; hfp = 0; vbp += vfp; vfp = 0; end
    e.valid = 1;
    e.hv = {16'(hd), 16'(hfp), 16'(hbp), 16'(hpw)};
    e.vv = {16'(m.vd), 16'(vfp), 16'(vbp), 16'(vpw)};
    e.hp = m.hn && (m.kind != 1);
    e.vp = m.vn && (m.kind != 1);
    sof = vbp + vpw;
    need = WC - sof;
    if (sof >= WC) e.lines = 0;
    else if (vfp < need) e.lines = vfp;
    else e.lines = need;
    htot = hd + hfp + hbp + hpw;
    vtot = m.vd + vfp + vbp + vpw;
    e.en = (e.lines != 0);
    e.fstart = e.en ? 32'((vtot - e.lines) * htot + 1) : 32'd0;
    e.bc = 8'h00;
    e.uc = 8'hFF;
    return e;
  endfunction

  task automatic drive(input mode_t m);
    h_disp_i = 16'(m.hd); h_ss_i = 16'(m.hs); h_se_i = 16'(m.he); h_tot_i = 16'(m.ht);
    v_disp_i = 16'(m.vd); v_ss_i = 16'(m.vs); v_se_i = 16'(m.ve); v_tot_i = 16'(m.vt);
    h_neg_i = m.hn; v_neg_i = m.vn; split_i = m.sp; if_kind_i = 2'(m.kind);
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic compare(input exp_t e, input string htag, input string vtag);
    check("R2 valid", 64'(valid_o), 64'(e.valid));
    check(htag, {h_active_o, h_fp_o, h_bp_o, h_pw_o}, e.hv);
    check(vtag, {v_active_o, v_fp_o, v_bp_o, v_pw_o}, e.vv);
    check("R5 polarity", {h_pol_o, v_pol_o}, {e.hp, e.vp});
    check("R7 fetch lines", 64'(fetch_lines_o), 64'(e.lines));
    check("R8 fetch", {fetch_en_o, fetch_start_o}, {e.en, e.fstart});
    check("R9 colours", {border_clr_o, underflow_clr_o}, {e.bc, e.uc});
  endtask

  task automatic run(input mode_t m, input string htag, input string vtag);
    @(negedge clk);
    drive(m);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    compare(model(m), htag, vtag);
    @(negedge clk);
    check("R10 done pulse", 64'(done_o), 64'd0);
  endtask

  function automatic mode_t mk(int hd, int hfp, int hpw, int hbp,
                               int vd, int vfp, int vpw, int vbp,
                               int kind, bit sp, bit hn, bit vn);
    mode_t m;
    m.hd = hd; m.hs = hd + hfp; m.he = m.hs + hpw; m.ht = m.he + hbp;
    m.vd = vd; m.vs = vd + vfp; m.ve = m.vs + vpw; m.vt = m.ve + vbp;
    m.kind = kind; m.sp = sp; m.hn = hn; m.vn = vn;
    return m;
  endfunction

  initial begin
    mode_t m, m2;
    exp_t e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset", {done_o, valid_o, fetch_en_o, fetch_start_o, underflow_clr_o, h_bp_o},
          '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset idle", {done_o, valid_o, v_active_o, fetch_lines_o}, '0);

    m = mk(1920, 88, 44, 148, 1080, 4, 5, 36, 0, 0, 1, 0);
    run(m, "R3 h derive", "R3 v derive");
    m = mk(1280, 110, 40, 220, 720, 20, 4, 10, 0, 0, 0, 1);
    run(m, "R3 h derive", "R7 fetch shortfall");
    m = mk(1280, 110, 40, 220, 720, 3, 4, 10, 0, 0, 1, 1);
    run(m, "R3 h derive", "R7 fetch whole vfp");
    m = mk(800, 40, 128, 88, 600, 9, 4, 20, 0, 0, 0, 0);
    run(m, "R3 h derive", "R7 sof equals worst");
    m = mk(800, 40, 128, 88, 600, 10, 4, 10, 0, 0, 0, 0);
    run(m, "R3 h derive", "R7 vfp equals need");
    m = mk(2000, 100, 40, 200, 1000, 15, 3, 5, 2, 0, 1, 1);
    run(m, "R6 h fold", "R6 v fold");
    m = mk(2000, 100, 40, 200, 1000, 15, 3, 5, 3, 0, 0, 0);
    run(m, "R6 h fold", "R6 v fold");
    m = mk(1000, 30, 20, 60, 480, 10, 2, 4, 1, 0, 1, 1);
    run(m, "R5 h cmd", "R5 v cmd");
    m = mk(3841, 177, 89, 297, 2160, 8, 10, 72, 0, 1, 0, 0);
    run(m, "R4 h split", "R4 v unchanged");
    m = mk(640, 16, 96, 48, 480, 10, 2, 33, 0, 0, 0, 0);
    m.hs = 600; run(m, "R2 h reject", "R2 v reject");
    m = mk(640, 16, 96, 48, 480, 10, 2, 33, 0, 0, 1, 1);
    m.ht = m.he - 1; run(m, "R2 h reject", "R2 v reject");
    m = mk(640, 16, 96, 48, 480, 10, 2, 33, 0, 0, 1, 1);
    m.ve = m.vs - 1; run(m, "R2 h reject", "R2 v reject");
    m = mk(640, 16, 96, 48, 480, 10, 2, 33, 2, 0, 1, 1);
    m.vs = 470; run(m, "R2 h reject", "R2 v reject");

    m = mk(1280, 110, 40, 220, 720, 20, 4, 10, 0, 0, 1, 0);
    run(m, "R3 h derive", "R3 v derive");
    e = model(m);
    m2 = mk(500, 5, 5, 5, 300, 1, 1, 1, 1, 1, 0, 1);
    drive(m2);
    repeat (6) @(negedge clk);
    compare(e, "R10 hold h", "R10 hold v");
    @(negedge clk);
    drive(m); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    drive(m2); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    compare(e, "R10 busy start h", "R10 busy start v");
    repeat (25) @(negedge clk);
    check("R10 ignored start no rerun", 64'(done_o), 64'd0);
    compare(e, "R10 ignored start h", "R10 ignored start v");

    for (int i = 0; i < 150; i++) begin
      m = mk(1 + $urandom_range(2000), $urandom_range(60), 1 + $urandom_range(20),
             $urandom_range(60), 1 + $urandom_range(1200), $urandom_range(30),
             1 + $urandom_range(6), $urandom_range(22), $urandom_range(3),
             1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      if ($urandom_range(9) == 0) m.vs = m.vd - 1;
      if ($urandom_range(9) == 0) m.he = m.hs - 1;
      run(m, "R3 random h", "R7 random v");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule